// File: doc/BRIEF.md
# Close-Loop Synchrocheck Qualifier

This block decides whether two network sections that are already electrically coupled may be paralleled by closing a breaker. On every clock it receives digitized voltage magnitudes, phase angles and frequencies for a reference side and a synchronizing side, together with threshold settings and control flags. It checks each voltage and each frequency against its window. It also checks the side-to-side differences in magnitude, angle and frequency against their limits.

Two results come out. `okOut` is the instantaneous qualification, registered once. `dlyOut` is time-qualified: it rises only after the qualification has held on a run of consecutive clocks equal to the programmed loop time. It falls on the same clock as `okOut`. The thresholds and the loop time are captured into shadow registers only while `start` is low, so a check in progress always works against fixed settings.

Top module: `closeLoopQual`

## Requirements
- R1: The magnitude check passes only when |refMag − synMag| is strictly less than the shadow `setVoltDiff`, for either sign of the difference.
- R2: The angles are ANG_W-bit two's-complement values covering a full turn. The difference refAng − synAng is wrapped modulo a full turn into [−half, +half). Its magnitude must be strictly less than the shadow `setAngDiff`. A wrapped difference of exactly −half has magnitude half.
- R3: The frequency check passes only when |refFreq − synFreq| is strictly less than the shadow `setFreqDiff`.
- R4: refMag and synMag must each be strictly above `setVoltLow` and strictly below `setVoltHigh`. refFreq and synFreq must each be strictly above `setFreqLow` and strictly below `setFreqHigh`. A value equal to a limit fails.
- R5: When `forbidLoop` and `coupled` are both high, qualification is blocked. Either flag alone has no effect.
- R6: `okOut` is high one clock after an edge at which `start`, `enLoop`, every window check and every difference check are all true and R5 does not block. Otherwise `okOut` is low.
- R7: With loop time L (shadow `setLoopTicks`), `dlyOut` rises on the clock where `okOut` has been high for L consecutive clocks. For L = 0 or L = 1, `dlyOut` equals `okOut`.
- R8: A single clock without qualification clears `dlyOut` on that same clock, with no drop-off delay. It also restarts the run count from zero.
- R9: The settings are sampled only on clocks where `start` is low. Changes while `start` is high have no effect on either output.
- R10: A synchronous reset `rst` clears both outputs and the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Synchrocheck start flag; settings are held while high |
| enLoop | input | 1 | Close-loop mode enable setting |
| forbidLoop | input | 1 | Forbid-loop setting |
| coupled | input | 1 | Systems-already-coupled flag |
| refMag | input | MAG_W | Reference-side voltage magnitude (unsigned) |
| synMag | input | MAG_W | Synchronizing-side voltage magnitude (unsigned) |
| refAng | input | ANG_W | Reference-side phase angle (two's complement, full turn) |
| synAng | input | ANG_W | Synchronizing-side phase angle |
| refFreq | input | FRQ_W | Reference-side frequency (unsigned) |
| synFreq | input | FRQ_W | Synchronizing-side frequency (unsigned) |
| setVoltDiff | input | MAG_W | Magnitude-difference limit |
| setAngDiff | input | ANG_W | Angle-difference limit (unsigned) |
| setFreqDiff | input | FRQ_W | Frequency-difference limit |
| setVoltLow | input | MAG_W | Undervoltage limit |
| setVoltHigh | input | MAG_W | Overvoltage limit |
| setFreqLow | input | FRQ_W | Underfrequency limit |
| setFreqHigh | input | FRQ_W | Overfrequency limit |
| setLoopTicks | input | TMR_W | Loop time in clocks |
| okOut | output | 1 | Instantaneous close-loop qualification |
| dlyOut | output | 1 | Time-qualified close-loop output |

## Verification
Each input pattern is applied on a falling edge and is sampled at the next rising edge. `okOut` for that pattern is therefore due one rising edge later. `dlyOut` is due on the same edge as the L-th consecutive high `okOut`, and falls on the same edge as `okOut`. The bench's reference model advances on every rising edge from the values it drove, with its own run counter and shadow settings. Both outputs are compared against the model at every falling edge, half a period after they settle. This way no check depends on event ordering at the active edge. Directed phases put each difference and window exactly at, and one step inside, its limit. Other phases break a run midway, change settings under a high `start`, and switch the loop time between 0, 1 and larger values.

// File: rtl/cloop_pkg.sv
package cloop_pkg;
  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic latchSet;   // capture settings into shadows
    logic qualify;    // all conditions true this clock
    logic clearTmr;   // restart run counter
    logic stepTmr;    // advance run counter
    logic dlyHit;     // run reaches loop time this clock
  } strobes_t;
endpackage

// File: rtl/cloop_absdiff.sv
module cloop_absdiff #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] limit,
  output logic         below
);
  localparam int XW = W + 1;
  logic [XW-1:0] raw;
  logic [XW-1:0] mag;

  always_comb begin
    raw   = {1'b0, a} - {1'b0, b};
    mag   = raw[XW-1] ? (~raw + 1'b1) : raw;
    below = mag < {1'b0, limit};
  end
endmodule

// File: rtl/cloop_datapath.sv
module cloop_datapath
  import cloop_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int ANG_W = 12,
  parameter int FRQ_W = 16,
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         strb,
  input  logic [MAG_W-1:0] refMag,
  input  logic [MAG_W-1:0] synMag,
  input  logic [ANG_W-1:0] refAng,
  input  logic [ANG_W-1:0] synAng,
  input  logic [FRQ_W-1:0] refFreq,
  input  logic [FRQ_W-1:0] synFreq,
  input  logic [MAG_W-1:0] setVoltDiff,
  input  logic [ANG_W-1:0] setAngDiff,
  input  logic [FRQ_W-1:0] setFreqDiff,
  input  logic [MAG_W-1:0] setVoltLow,
  input  logic [MAG_W-1:0] setVoltHigh,
  input  logic [FRQ_W-1:0] setFreqLow,
  input  logic [FRQ_W-1:0] setFreqHigh,
  input  logic [TMR_W-1:0] setLoopTicks,
  output logic             checksPass,
  output logic             nearLimit,
  output logic             atLimit,
  output logic             okOut,
  output logic             dlyOut
);
  localparam int CW = TMR_W + 1;

  // Shadow settings
  logic [MAG_W-1:0] shVoltDiff, shVoltLow, shVoltHigh;
  logic [ANG_W-1:0] shAngDiff;
  logic [FRQ_W-1:0] shFreqDiff, shFreqLow, shFreqHigh;
  logic [TMR_W-1:0] shLoop;
  logic [TMR_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shVoltDiff <= '0; shVoltLow <= '0; shVoltHigh <= '0;
      shAngDiff  <= '0;
      shFreqDiff <= '0; shFreqLow <= '0; shFreqHigh <= '0;
      shLoop     <= '0;
    end else if (strb.latchSet) begin
      shVoltDiff <= setVoltDiff; shVoltLow <= setVoltLow; shVoltHigh <= setVoltHigh;
      shAngDiff  <= setAngDiff;
      shFreqDiff <= setFreqDiff; shFreqLow <= setFreqLow; shFreqHigh <= setFreqHigh;
      shLoop     <= setLoopTicks;
    end
  end

  // Difference checks
  logic magOk, frqOk, angOk;
  cloop_absdiff #(.W(MAG_W)) u_magDiff (.a(refMag),  .b(synMag),  .limit(shVoltDiff), .below(magOk));
  cloop_absdiff #(.W(FRQ_W)) u_frqDiff (.a(refFreq), .b(synFreq), .limit(shFreqDiff), .below(frqOk));

  logic [ANG_W-1:0] angWrap, angAbs;
  always_comb begin
    angWrap = refAng - synAng;                       // modulo one turn
    angAbs  = angWrap[ANG_W-1] ? (~angWrap + 1'b1) : angWrap;
    angOk   = angAbs < shAngDiff;
  end

  // Window checks (strict)
  logic winOk;
  always_comb begin
    winOk = (refMag  > shVoltLow) && (refMag  < shVoltHigh) &&
            (synMag  > shVoltLow) && (synMag  < shVoltHigh) &&
            (refFreq > shFreqLow) && (refFreq < shFreqHigh) &&
            (synFreq > shFreqLow) && (synFreq < shFreqHigh);
    checksPass = winOk && magOk && angOk && frqOk;
  end

  // Run timer
  always_comb begin
    atLimit   = runCnt >= shLoop;
    nearLimit = ({1'b0, runCnt} + CW'(1)) >= {1'b0, shLoop};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
      okOut  <= 1'b0;
      dlyOut <= 1'b0;
    end else begin
      if (strb.clearTmr)     runCnt <= '0;
      else if (strb.stepTmr) runCnt <= runCnt + 1'b1;
      okOut  <= strb.qualify;
      dlyOut <= strb.dlyHit;
    end
  end
endmodule

// File: rtl/cloop_control.sv
module cloop_control
  import cloop_pkg::*;
(
  input  logic     start,
  input  logic     enLoop,
  input  logic     forbidLoop,
  input  logic     coupled,
  input  logic     checksPass,
  input  logic     nearLimit,
  input  logic     atLimit,
  output strobes_t strb
);
  logic enabled;
  always_comb begin
    enabled       = start && enLoop && !(forbidLoop && coupled);
    strb.latchSet = !start;
    strb.qualify  = enabled && checksPass;
    strb.clearTmr = !strb.qualify;
    strb.stepTmr  = strb.qualify && !atLimit;
    strb.dlyHit   = strb.qualify && nearLimit;
  end
endmodule

// File: rtl/closeLoopQual.sv
module closeLoopQual
  import cloop_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int ANG_W = 12,
  parameter int FRQ_W = 16,
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             enLoop,
  input  logic             forbidLoop,
  input  logic             coupled,
  input  logic [MAG_W-1:0] refMag,
  input  logic [MAG_W-1:0] synMag,
  input  logic [ANG_W-1:0] refAng,
  input  logic [ANG_W-1:0] synAng,
  input  logic [FRQ_W-1:0] refFreq,
  input  logic [FRQ_W-1:0] synFreq,
  input  logic [MAG_W-1:0] setVoltDiff,
  input  logic [ANG_W-1:0] setAngDiff,
  input  logic [FRQ_W-1:0] setFreqDiff,
  input  logic [MAG_W-1:0] setVoltLow,
  input  logic [MAG_W-1:0] setVoltHigh,
  input  logic [FRQ_W-1:0] setFreqLow,
  input  logic [FRQ_W-1:0] setFreqHigh,
  input  logic [TMR_W-1:0] setLoopTicks,
  output logic             okOut,
  output logic             dlyOut
);
  strobes_t strb;
  logic checksPass, nearLimit, atLimit;

  cloop_control u_ctrl (
    .start(start), .enLoop(enLoop), .forbidLoop(forbidLoop), .coupled(coupled),
    .checksPass(checksPass), .nearLimit(nearLimit), .atLimit(atLimit), .strb(strb)
  );

  cloop_datapath #(.MAG_W(MAG_W), .ANG_W(ANG_W), .FRQ_W(FRQ_W), .TMR_W(TMR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .refMag(refMag), .synMag(synMag), .refAng(refAng), .synAng(synAng),
    .refFreq(refFreq), .synFreq(synFreq),
    .setVoltDiff(setVoltDiff), .setAngDiff(setAngDiff), .setFreqDiff(setFreqDiff),
    .setVoltLow(setVoltLow), .setVoltHigh(setVoltHigh),
    .setFreqLow(setFreqLow), .setFreqHigh(setFreqHigh), .setLoopTicks(setLoopTicks),
    .checksPass(checksPass), .nearLimit(nearLimit), .atLimit(atLimit),
    .okOut(okOut), .dlyOut(dlyOut)
  );
endmodule

// File: rtl/cloop_checker.sv
module cloop_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic enLoop,
  input logic forbidLoop,
  input logic coupled,
  input logic okOut,
  input logic dlyOut
);
  AST_DLY_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    dlyOut |-> okOut);                                               // R8

  AST_OK_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    okOut |-> ($past(start) && $past(enLoop)));                      // R6

  AST_FORBID_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    okOut |-> !($past(forbidLoop) && $past(coupled)));               // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!okOut && !dlyOut));                                    // R10
endmodule

bind closeLoopQual cloop_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .enLoop(enLoop),
  .forbidLoop(forbidLoop), .coupled(coupled), .okOut(okOut), .dlyOut(dlyOut)
);

// File: tb/closeLoopQual_tb.sv
module closeLoopQual_tb;
  localparam int MAG_W = 12;
  localparam int ANG_W = 12;
  localparam int FRQ_W = 16;
  localparam int TMR_W = 10;
  localparam int HALF  = 1 << (ANG_W - 1);
  localparam int TURN  = 1 << ANG_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst, start, enLoop, forbidLoop, coupled;
  logic [MAG_W-1:0] refMag, synMag, setVoltDiff, setVoltLow, setVoltHigh;
  logic [ANG_W-1:0] refAng, synAng, setAngDiff;
  logic [FRQ_W-1:0] refFreq, synFreq, setFreqDiff, setFreqLow, setFreqHigh;
  logic [TMR_W-1:0] setLoopTicks;
  logic okOut, dlyOut;

  closeLoopQual #(.MAG_W(MAG_W), .ANG_W(ANG_W), .FRQ_W(FRQ_W), .TMR_W(TMR_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .enLoop(enLoop), .forbidLoop(forbidLoop),
    .coupled(coupled), .refMag(refMag), .synMag(synMag), .refAng(refAng), .synAng(synAng),
    .refFreq(refFreq), .synFreq(synFreq), .setVoltDiff(setVoltDiff), .setAngDiff(setAngDiff),
    .setFreqDiff(setFreqDiff), .setVoltLow(setVoltLow), .setVoltHigh(setVoltHigh),
    .setFreqLow(setFreqLow), .setFreqHigh(setFreqHigh), .setLoopTicks(setLoopTicks),
    .okOut(okOut), .dlyOut(dlyOut)
  );

  int errors = 0;
  int checks = 0;
  string curReq = "R10";
  bit running = 0;
  bit finished = 0;

  // Behavioural reference model
  int shDu, shDa, shDf, shUv, shOv, shUf, shOf, shL;
  int run;
  bit mOk, mDly, cond;
  int dMag, dFrq, dAng;

  always @(posedge clk) begin
    if (rst) begin
      shDu = 0; shDa = 0; shDf = 0; shUv = 0; shOv = 0; shUf = 0; shOf = 0; shL = 0;
      run = 0; mOk = 0; mDly = 0;
    end else begin
      dMag = int'(refMag) - int'(synMag);   if (dMag < 0) dMag = -dMag;
      dFrq = int'(refFreq) - int'(synFreq); if (dFrq < 0) dFrq = -dFrq;
      dAng = int'($signed(refAng)) - int'($signed(synAng));
      if (dAng >= HALF) dAng -= TURN;
      else if (dAng < -HALF) dAng += TURN;
      if (dAng < 0) dAng = -dAng;
      cond = start && enLoop && !(forbidLoop && coupled)
          && dMag < shDu && dAng < shDa && dFrq < shDf
          && int'(refMag) > shUv && int'(refMag) < shOv
          && int'(synMag) > shUv && int'(synMag) < shOv
          && int'(refFreq) > shUf && int'(refFreq) < shOf
          && int'(synFreq) > shUf && int'(synFreq) < shOf;
      if (cond) run = run + 1; else run = 0;
      mOk  = cond;
      mDly = cond && (run >= shL);
      if (!start) begin
        shDu = setVoltDiff; shDa = setAngDiff; shDf = setFreqDiff;
        shUv = setVoltLow;  shOv = setVoltHigh;
        shUf = setFreqLow;  shOf = setFreqHigh; shL = setLoopTicks;
      end
    end
    running = 1;
  end

  always @(negedge clk) begin
    if (running && !finished) begin
      checks++;
      if (okOut !== mOk) begin
        errors++;
        $display("FAIL %s okOut actual=%b expected=%b t=%0t", curReq, okOut, mOk, $time);
      end
      checks++;
      if (dlyOut !== mDly) begin
        errors++;
        $display("FAIL %s dlyOut actual=%b expected=%b t=%0t", curReq, dlyOut, mDly, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nominal(input int loopT);
    start = 0; enLoop = 1; forbidLoop = 0; coupled = 0;
    refMag = 1000; synMag = 1000; refAng = 0; synAng = 0;
    refFreq = 5000; synFreq = 5000;
    setVoltDiff = 50; setAngDiff = 100; setFreqDiff = 20;
    setVoltLow = 800; setVoltHigh = 1200; setFreqLow = 4900; setFreqHigh = 5100;
    setLoopTicks = TMR_W'(loopT);
    cyc(2);
    start = 1;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1;
    nominal(5);
    start = 0;
    curReq = "R10"; cyc(3);
    rst = 0;

    curReq = "R6"; nominal(5); cyc(10);
    enLoop = 0; cyc(4); enLoop = 1; cyc(3);

    curReq = "R7"; nominal(1); cyc(5);
    nominal(0); cyc(5);
    nominal(12); cyc(16);

    curReq = "R1"; nominal(3);
    synMag = 1049; cyc(5); synMag = 1050; cyc(3);
    synMag = 951;  cyc(5); synMag = 950;  cyc(3);

    curReq = "R2"; nominal(2);
    refAng = 12'd1900; synAng = -12'sd1900; cyc(3);   // wrapped diff 296
    start = 0; setAngDiff = 296; cyc(2); start = 1; cyc(4);
    start = 0; setAngDiff = 297; cyc(2); start = 1; cyc(4);
    refAng = 12'd1024; synAng = -12'sd1024;            // diff of exactly half
    start = 0; setAngDiff = 2048; cyc(2); start = 1; cyc(4);
    start = 0; setAngDiff = 2049; cyc(2); start = 1; cyc(4);
    refAng = 12'd30; synAng = 12'd120; cyc(4);

    curReq = "R3"; nominal(2);
    synFreq = 5019; cyc(4); synFreq = 5020; cyc(3); synFreq = 4981; cyc(4); synFreq = 4980; cyc(3);

    curReq = "R4"; nominal(1);
    refMag = 1200; synMag = 1170; cyc(3); refMag = 1199; cyc(3);
    refMag = 820; synMag = 800; cyc(3); synMag = 801; cyc(3);
    refMag = 1000; synMag = 1000;
    refFreq = 5100; synFreq = 5095; cyc(3); refFreq = 5099; cyc(3);
    refFreq = 4900; synFreq = 4905; cyc(3); refFreq = 4901; cyc(3);

    curReq = "R5"; nominal(2);
    forbidLoop = 1; cyc(4); coupled = 1; cyc(4); forbidLoop = 0; cyc(4);

    curReq = "R8"; nominal(5);
    cyc(3); synMag = 1100; cyc(1); synMag = 1000; cyc(8);
    cyc(2); synAng = 12'd500; cyc(1); synAng = 0; cyc(3); start = 0; cyc(1); start = 1; cyc(7);

    curReq = "R9"; nominal(6);
    setLoopTicks = 1; setVoltDiff = 0; setVoltHigh = 900; cyc(9);
    start = 0; cyc(2); start = 1; cyc(3);

    curReq = "R10"; nominal(1); cyc(3); rst = 1; cyc(2); rst = 0; cyc(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule